// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller with Wait States

This unit sits between a processor core and an external bus on which the low address byte and the data share the same eight lines. The core hands it a transfer: an address, write data, a direction flag and a memory-or-I/O flag. The unit then runs one bus cycle. The upper address byte goes out on dedicated lines. The lower byte appears on the shared lines while the latch enable is high, so that external logic can catch it. The shared lines then carry data, framed by an active-low read or write strobe. A slow device pulls the ready input low to stretch the strobe phase by any number of clocks. Read data comes back to the core together with a one-clock completion pulse.

A second master can ask for the bus with the hold input. The unit answers only between cycles. It lets go of every bus line and raises the acknowledge. It takes the bus back one clock after hold is withdrawn. The pad tristate is modelled by output-enable signals: an enable low means the corresponding lines float.

The sequencer has seven named states:
- FLOAT is the reset state. All lines float. It moves to HOLD if hold is high, otherwise to IDLE.
- IDLE drives the strobes inactive. Hold wins over a request here. A request moves it to T1.
- T1 is the address phase. It always moves to T2.
- T2 is the first strobe clock. It moves to T3 if ready is high and to TW if ready is low.
- TW is a wait state. It follows the same ready rule as T2.
- T3 releases the strobe and signals completion. It moves to HOLD if hold is high, otherwise to IDLE.
- HOLD leaves the bus released. It stays in HOLD while hold is high and returns to IDLE when hold is low.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: While rst_n is low, addr_hi_oe, ad_oe, ctrl_oe, hlda and done are all 0 and rd_data is 0. At the first clock after release the unit enters IDLE with ctrl_oe=1 and rd_n=wr_n=1.
- R2: A request is accepted in IDLE when req_valid=1 and hold=0. It is latched at that edge, so the req_* inputs may change afterwards. The next clock is T1: ale=1, addr_hi=addr[15:8] with addr_hi_oe=1, ad_o=addr[7:0] with ad_oe=1, and rd_n=wr_n=1. ale is high for exactly one clock.
- R3: In a read (req_write=0), rd_n is 0 from the clock after T1 until the end of the last strobe clock. During that time ad_oe=0 and ale=0.
- R4: In a write (req_write=1), wr_n is 0 over the same strobe clocks. ad_oe=1 and ad_o carries the write data from T2 through T3.
- R5: rd_n and wr_n are never low together.
- R6: ready is looked at only on strobe clocks. Each low sample adds one wait clock with the strobe held. A cycle with W low samples lasts 3+W clocks from ale to done. The value of ready during T1 has no effect.
- R7: In a read, the ad_i value at the clock edge that ends the strobe (ready high) appears on rd_data in the done clock. It is held there until the next read. A write leaves rd_data unchanged.
- R8: done is a single-clock pulse in T3, with both strobes high.
- R9: Hold raised during a cycle does not cut the cycle short; hlda stays 0 until after T3. Whenever hlda=1, addr_hi_oe, ad_oe and ctrl_oe are all 0.
- R10: With hold=1 and req_valid=1 in the same IDLE clock, hold wins. The request runs after release. One clock after hold is sampled low, hlda=0 and ctrl_oe=1.
- R11: io_m is 1 for I/O cycles and 0 for memory cycles. io_m and addr_hi stay stable from T1 through T3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core requests a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Last read data |
| done | output | 1 | One-clock completion pulse |
| addr_hi | output | 8 | Upper address byte |
| addr_hi_oe | output | 1 | Drive enable for addr_hi |
| ad_o | output | 8 | Shared bus, outgoing value |
| ad_i | input | 8 | Shared bus, incoming value |
| ad_oe | output | 1 | Drive enable for the shared bus |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | I/O-versus-memory status |
| ctrl_oe | output | 1 | Drive enable for ale, rd_n, wr_n, io_m |
| ready | input | 1 | Device ready; low inserts wait states |
| hold | input | 1 | Bus release request |
| hlda | output | 1 | Bus release acknowledge |

## Verification
A bus-release request can land in the same clock as a transfer request, or in the middle of a transfer that ready is stretching. Both cases are provoked on purpose.

In the first case, hold and req_valid are raised in the same IDLE clock. The bench expects hlda first and all enables low. The latched request must then appear as an ale clock exactly two clocks after hold drops.

In the second case, hold is raised on the first strobe clock of a cycle with wait states. The bench expects every strobe, address and data value to continue unchanged through done. hlda must appear only in the clock after T3.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        ST_FLOAT = 3'd0,
        ST_IDLE  = 3'd1,
        ST_T1    = 3'd2,
        ST_T2    = 3'd3,
        ST_TW    = 3'd4,
        ST_T3    = 3'd5,
        ST_HOLD  = 3'd6
    } bus_state_t;

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       hold,
    input  logic       ready,
    output bus_state_t state,
    output logic       accept,
    output logic       strobe_end
);

    bus_state_t state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FLOAT;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FLOAT: state_nxt = hold ? ST_HOLD : ST_IDLE;
            ST_IDLE: begin
                if (hold)           state_nxt = ST_HOLD;
                else if (req_valid) state_nxt = ST_T1;
                else                state_nxt = ST_IDLE;
            end
            ST_T1:        state_nxt = ST_T2;
            ST_T2, ST_TW: state_nxt = ready ? ST_T3 : ST_TW;
            ST_T3:        state_nxt = hold ? ST_HOLD : ST_IDLE;
            ST_HOLD:      state_nxt = hold ? ST_HOLD : ST_IDLE;
            default:      state_nxt = ST_FLOAT;
        endcase
    end

    assign accept     = (state == ST_IDLE) && req_valid && !hold;
    assign strobe_end = ((state == ST_T2) || (state == ST_TW)) && ready;

endmodule

// File: rtl/mbus_req.sv
module mbus_req #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          strobe_end,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    input  logic          req_io,
    input  logic [DW-1:0] ad_i,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_wdata,
    output logic          lat_write,
    output logic          lat_io,
    output logic [DW-1:0] rd_data
);

    // request latched at acceptance so the core may move on
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_write <= 1'b0;
            lat_io    <= 1'b0;
        end else if (load) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_write <= req_write;
            lat_io    <= req_io;
        end
    end

    // read data taken at the edge that closes the strobe phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       rd_data <= '0;
        else if (strobe_end && !lat_write) rd_data <= ad_i;
    end

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
    import mbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  bus_state_t    state,
    input  logic [AW-1:0] lat_addr,
    input  logic [DW-1:0] lat_wdata,
    input  logic          lat_write,
    input  logic          lat_io,
    output logic [AW-DW-1:0] addr_hi,
    output logic          addr_hi_oe,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          io_m,
    output logic          ctrl_oe,
    output logic          hlda,
    output logic          done
);

    localparam int HW = AW - DW;

    always_comb begin
        addr_hi    = lat_addr[AW-1:DW];
        addr_hi_oe = 1'b0;
        ad_o       = lat_addr[DW-1:0];
        ad_oe      = 1'b0;
        ale        = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        io_m       = lat_io;
        ctrl_oe    = 1'b0;
        hlda       = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_FLOAT: ;
            ST_IDLE: ctrl_oe = 1'b1;
            ST_T1: begin
                ctrl_oe    = 1'b1;
                addr_hi_oe = 1'b1;
                ad_oe      = 1'b1;
                ale        = 1'b1;
            end
            ST_T2, ST_TW: begin
                ctrl_oe    = 1'b1;
                addr_hi_oe = 1'b1;
                rd_n       = lat_write;
                wr_n       = !lat_write;
                ad_oe      = lat_write;
                ad_o       = lat_wdata;
            end
            ST_T3: begin
                ctrl_oe    = 1'b1;
                addr_hi_oe = 1'b1;
                ad_oe      = lat_write;
                ad_o       = lat_wdata;
                done       = 1'b1;
            end
            ST_HOLD: hlda = 1'b1;
            default: ;
        endcase
    end

    if (HW < 1) begin : g_bad_width
        initial $display("mbus_pins: AW must exceed DW");
    end

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
    import mbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic [AW-DW-1:0] addr_hi,
    output logic          addr_hi_oe,
    output logic [DW-1:0] ad_o,
    input  logic [DW-1:0] ad_i,
    output logic          ad_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          io_m,
    output logic          ctrl_oe,
    input  logic          ready,
    input  logic          hold,
    output logic          hlda
);

    bus_state_t    state;
    logic          accept;
    logic          strobe_end;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic          lat_write;
    logic          lat_io;

    mbus_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .hold       (hold),
        .ready      (ready),
        .state      (state),
        .accept     (accept),
        .strobe_end (strobe_end)
    );

    mbus_req #(.AW(AW), .DW(DW)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .strobe_end (strobe_end),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_write  (req_write),
        .req_io     (req_io),
        .ad_i       (ad_i),
        .lat_addr   (lat_addr),
        .lat_wdata  (lat_wdata),
        .lat_write  (lat_write),
        .lat_io     (lat_io),
        .rd_data    (rd_data)
    );

    mbus_pins #(.AW(AW), .DW(DW)) u_pins (
        .state      (state),
        .lat_addr   (lat_addr),
        .lat_wdata  (lat_wdata),
        .lat_write  (lat_write),
        .lat_io     (lat_io),
        .addr_hi    (addr_hi),
        .addr_hi_oe (addr_hi_oe),
        .ad_o       (ad_o),
        .ad_oe      (ad_oe),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .io_m       (io_m),
        .ctrl_oe    (ctrl_oe),
        .hlda       (hlda),
        .done       (done)
    );

    // R2: address phase lasts one clock
    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R3: read strobe opens right after the address phase, bus released
    a_r3_read_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(ale));
    a_r3_read_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R4: write strobe opens right after the address phase
    a_r4_write_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $past(ale));

    // R5: strobes mutually exclusive
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R6: a low ready keeps the strobe phase going
    a_r6_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_n || !wr_n) && !ready) |=> ((!rd_n || !wr_n) && !done));

    // R7: completion follows a high ready sample
    a_r7_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ready));

    // R8: completion is a single pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: no release in the middle of a cycle; release floats every line
    a_r9_no_midcycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_T1, ST_T2, ST_TW}) |=> !hlda);
    a_r9_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ctrl_oe && !ad_oe && !addr_hi_oe));

    // R10: bus taken back one clock after hold drops
    a_r10_takeback: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !hold) |=> (!hlda && ctrl_oe));

    // R11: status and upper address stable across the cycle
    a_r11_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_T2, ST_TW, ST_T3}) |-> ($stable(io_m) && $stable(addr_hi)));

endmodule

// File: tb/mbus_cycle_ctrl_test.sv
module mbus_cycle_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        done;
    logic [7:0]  addr_hi;
    logic        addr_hi_oe;
    logic [7:0]  ad_o;
    logic [7:0]  ad_i = '0;
    logic        ad_oe;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic        io_m;
    logic        ctrl_oe;
    logic        ready = 1'b0;
    logic        hold = 1'b0;
    logic        hlda;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mbus_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .done(done), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
        .ad_o(ad_o), .ad_i(ad_i), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .io_m(io_m), .ctrl_oe(ctrl_oe), .ready(ready),
        .hold(hold), .hlda(hlda)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_cycle(input logic [15:0] a, input logic [7:0] wd, input bit wr,
                             input bit io, input int waits, input logic [7:0] rv,
                             input bit ready_t1, input bit hold_mid);
        logic [7:0] prev_rd;
        @(negedge clk);
        prev_rd   = rd_data;
        req_addr  = a;
        req_wdata = wd;
        req_write = wr;
        req_io    = io;
        req_valid = 1'b1;
        ready     = ready_t1;
        ad_i      = ~rv;
        @(negedge clk);
        // T1 (R2)
        chk(ale === 1'b1, "R2", ale, 1);
        chk(addr_hi === a[15:8] && addr_hi_oe === 1'b1, "R2", addr_hi, a[15:8]);
        chk(ad_oe === 1'b1 && ad_o === a[7:0], "R2", ad_o, a[7:0]);
        chk(rd_n === 1'b1 && wr_n === 1'b1, "R2", {rd_n, wr_n}, 2'b11);
        chk(io_m === io, "R11", io_m, io);
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~wd;
        req_write = ~wr;
        req_io    = ~io;
        for (int k = 0; k <= waits; k++) begin
            @(negedge clk);
            if (wr) begin
                chk(wr_n === 1'b0 && rd_n === 1'b1, "R4", {rd_n, wr_n}, 2'b10);
                chk(ad_oe === 1'b1 && ad_o === wd, "R4", ad_o, wd);
            end else begin
                chk(rd_n === 1'b0 && wr_n === 1'b1, "R3", {rd_n, wr_n}, 2'b01);
                chk(ad_oe === 1'b0 && ale === 1'b0, "R3", {ad_oe, ale}, 2'b00);
            end
            chk(done === 1'b0, "R6", done, 0);
            chk(io_m === io && addr_hi === a[15:8], "R11", {io_m, addr_hi}, {io, a[15:8]});
            chk(hlda === 1'b0, "R9", hlda, 0);
            if (k == 0 && hold_mid) hold = 1'b1;
            ready = (k == waits);
            ad_i  = (k == waits) ? rv : ~rv;
        end
        @(negedge clk);
        // T3: 3+waits clocks after ale (R6, R8)
        chk(done === 1'b1 && rd_n === 1'b1 && wr_n === 1'b1, "R8", {done, rd_n, wr_n}, 3'b111);
        if (wr) begin
            chk(rd_data === prev_rd, "R7", rd_data, prev_rd);
            chk(ad_oe === 1'b1 && ad_o === wd, "R4", ad_o, wd);
        end else begin
            chk(rd_data === rv, "R7", rd_data, rv);
        end
        chk(hlda === 1'b0, "R9", hlda, 0);
        ad_i  = 8'h00;
        ready = 1'b0;
        @(negedge clk);
        chk(done === 1'b0, "R8", done, 0);
        if (hold_mid)
            chk(hlda === 1'b1 && ctrl_oe === 1'b0 && ad_oe === 1'b0 && addr_hi_oe === 1'b0,
                "R9", {hlda, ctrl_oe, ad_oe, addr_hi_oe}, 4'b1000);
        else
            chk(hlda === 1'b0 && ctrl_oe === 1'b1, "R9", {hlda, ctrl_oe}, 2'b01);
        if (!wr) chk(rd_data === rv, "R7", rd_data, rv);
        else     chk(rd_data === prev_rd, "R7", rd_data, prev_rd);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(addr_hi_oe === 1'b0 && ad_oe === 1'b0 && ctrl_oe === 1'b0, "R1",
            {addr_hi_oe, ad_oe, ctrl_oe}, 3'b000);
        chk(hlda === 1'b0 && done === 1'b0 && rd_data === 8'h00, "R1",
            {hlda, done, rd_data}, 10'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_oe === 1'b1 && rd_n === 1'b1 && wr_n === 1'b1, "R1",
            {ctrl_oe, rd_n, wr_n}, 3'b111);

        // sweep: kind x direction x wait count
        for (int io = 0; io < 2; io++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int w = 0; w < 4; w++) begin
                    int idx;
                    bit hm;
                    idx = io * 8 + wr * 4 + w;
                    hm  = (w == 2);
                    run_cycle(16'(16'h1234 + idx * 16'h0F1D), 8'(idx * 29 + 3),
                              wr[0], io[0], w, 8'(idx * 53 + 11), idx[0], hm);
                    if (hm) begin
                        // R10: takeback one clock after hold drops
                        @(negedge clk);
                        chk(hlda === 1'b1, "R9", hlda, 1);
                        hold = 1'b0;
                        @(negedge clk);
                        chk(hlda === 1'b0 && ctrl_oe === 1'b1, "R10", {hlda, ctrl_oe}, 2'b01);
                    end
                end
            end
        end

        // R10: hold and request in the same idle clock
        @(negedge clk);
        req_addr  = 16'hA55A;
        req_write = 1'b0;
        req_io    = 1'b1;
        req_valid = 1'b1;
        hold      = 1'b1;
        ready     = 1'b1;
        ad_i      = 8'h3C;
        @(negedge clk);
        chk(hlda === 1'b1 && ale === 1'b0 && ctrl_oe === 1'b0, "R10",
            {hlda, ale, ctrl_oe}, 3'b100);
        repeat (2) @(negedge clk);
        chk(hlda === 1'b1 && ad_oe === 1'b0, "R10", {hlda, ad_oe}, 2'b10);
        hold = 1'b0;
        @(negedge clk);
        chk(hlda === 1'b0 && ctrl_oe === 1'b1 && ale === 1'b0, "R10",
            {hlda, ctrl_oe, ale}, 3'b010);
        @(negedge clk);
        chk(ale === 1'b1 && addr_hi === 8'hA5 && ad_o === 8'h5A && io_m === 1'b1, "R10",
            {ale, addr_hi, ad_o, io_m}, {1'b1, 16'hA55A, 1'b1});
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(done === 1'b1 && rd_data === 8'h3C, "R7", {done, rd_data}, {1'b1, 8'h3C});
        @(negedge clk);

        // R1: reset in the middle of a write floats all lines at once
        req_addr  = 16'h0101;
        req_wdata = 8'h77;
        req_write = 1'b1;
        req_io    = 1'b0;
        req_valid = 1'b1;
        ready     = 1'b0;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        chk(wr_n === 1'b0, "R4", wr_n, 0);
        rst_n = 1'b0;
        #1;
        chk(ctrl_oe === 1'b0 && ad_oe === 1'b0 && addr_hi_oe === 1'b0 && done === 1'b0, "R1",
            {ctrl_oe, ad_oe, addr_hi_oe, done}, 4'b0000);
        chk(rd_data === 8'h00, "R1", rd_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_oe === 1'b1 && wr_n === 1'b1 && rd_n === 1'b1 && ale === 1'b0, "R1",
            {ctrl_oe, wr_n, rd_n, ale}, 4'b1110);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule